// File: doc/BRIEF.md
# UART Modem Status Register

This block holds the modem status of one UART channel. It watches four active-low modem handshake inputs: carrier detect, ring indicator, data set ready and clear to send. Each input passes through a synchronizer, and the block reports the true, asserted-high state of each line as a read-only status bit. Next to each status bit sits a sticky change flag. A flag records that its line changed since the last read of the register. The ring flag is the exception: it records only the moment the ring pin is pulled low.

A loopback enable redirects the four status bits away from the pins. In loopback they take their values from four modem control bits, with a fixed crossover between control bits and status bits. While loopback is active, the change flags follow transitions of those control values. The surrounding UART reads the whole byte on `rd_data` at any time. It raises `rd_stb` for one cycle to mark a read, and that read clears the change flags at the following clock edge.

Top module: `modem_status_reg`

## Requirements
- R1: While reset is high and in the cycle after it, `rd_data` reads 0x00 with the pins idle (high) and loopback off. Bit layout: [7] carrier, [6] ring, [5] data set ready, [4] clear to send, [3] carrier change, [2] ring event, [1] data-set-ready change, [0] clear-to-send change.
- R2: With loopback off, each of `rd_data[7:4]` is the inverse of its pin. The pin is seen two clock edges after it changes.
- R3: With loopback on, `rd_data[7]`=`mctl[3]`, `rd_data[6]`=`mctl[2]`, `rd_data[5]`=`mctl[0]` and `rd_data[4]`=`mctl[1]`, combinationally.
- R4: The carrier, data-set-ready and clear-to-send change flags set one edge after their status bit changes, in either direction.
- R5: The ring flag sets only when the ring status bit rises, which is a falling edge of the ring pin. A rising ring pin leaves the flag clear.
- R6: Change flags stay set until a read. A cycle with `rd_stb` high shows the flags before clearing and clears them at the next edge.
- R7: A change detected at the same edge a read takes effect leaves that flag set after the read.
- R8: In loopback, the change flags follow transitions of the looped control values, and activity on the pins has no effect on `rd_data`.
- R9: Idle pins after reset produce no change flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dsr_n | input | 1 | Data set ready pin, active low, asynchronous |
| cts_n | input | 1 | Clear to send pin, active low, asynchronous |
| loop_en | input | 1 | Loopback enable |
| mctl | input | 4 | Modem control bits: [3] out2, [2] out1, [1] request to send, [0] terminal ready |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| rd_data | output | 8 | Status byte |

## Verification
The assertions assume that `loop_en` and `mctl` are synchronous to `clk`, that `rd_stb` is a clean single-cycle pulse, and that loopback is either off during reset or its control values are zero then, so that the history matches the status lines when reset ends. The bench drives every input one time unit after a rising edge and holds loopback off with the controls at zero through reset. It also parks the pins at their idle level before it switches the loopback mode, so that a mode change never flags a change.

// File: rtl/msr_pkg.sv
package msr_pkg;

    // Number of modem lines handled by the register.
    localparam int unsigned LINES       = 4;
    localparam int unsigned SYNC_DEPTH  = 2;
    localparam int unsigned BYTE_W      = 2 * LINES;

    // Line positions inside a line vector; they fix the read byte layout.
    localparam int unsigned IDX_CTS = 0;
    localparam int unsigned IDX_DSR = 1;
    localparam int unsigned IDX_RI  = 2;
    localparam int unsigned IDX_DCD = 3;

    // Control bit positions of the modem control word.
    localparam int unsigned CTL_DTR  = 0;
    localparam int unsigned CTL_RTS  = 1;
    localparam int unsigned CTL_OUT1 = 2;
    localparam int unsigned CTL_OUT2 = 3;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } msr_lines_t;

    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_RISE = 1'b1
    } edge_kind_e;

    typedef struct packed {
        msr_lines_t status;
        msr_lines_t flags;
    } msr_byte_t;

    // Which transitions of a status line raise its flag.
    function automatic edge_kind_e edge_kind(input int unsigned idx);
        return (idx == IDX_RI) ? EDGE_RISE : EDGE_ANY;
    endfunction

    // Crossover used in loopback: control word onto status lines.
    function automatic msr_lines_t loop_map(input logic [LINES-1:0] ctl);
        msr_lines_t m;
        m.dcd = ctl[CTL_OUT2];
        m.ri  = ctl[CTL_OUT1];
        m.dsr = ctl[CTL_DTR];
        m.cts = ctl[CTL_RTS];
        return m;
    endfunction

    function automatic msr_lines_t pins_to_lines(input logic [LINES-1:0] pins_n);
        msr_lines_t m;
        m = msr_lines_t'(~pins_n);
        return m;
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Reset value is the idle (high) level of active-low pins.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/msr_line_source.sv
module msr_line_source
    import msr_pkg::*;
(
    input  logic [LINES-1:0] pins_n_sync,
    input  logic             loop_en,
    input  logic [LINES-1:0] mctl,
    output msr_lines_t       status
);
    msr_lines_t from_pins;
    msr_lines_t from_loop;

    always_comb begin
        from_pins = pins_to_lines(pins_n_sync);
        from_loop = loop_map(mctl);
        status    = loop_en ? from_loop : from_pins;
    end
endmodule

// File: rtl/msr_delta_flags.sv
module msr_delta_flags
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] status,
    input  logic             rd_stb,
    output logic [LINES-1:0] hist,
    output logic [LINES-1:0] flags
);
    logic [LINES-1:0] hit;

    // History holds the status of the previous cycle; inactive after reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= status;
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam edge_kind_e KIND = edge_kind(g);
        if (KIND == EDGE_RISE) begin : g_rise
            assign hit[g] = status[g] & ~hist[g];
        end else begin : g_any
            assign hit[g] = status[g] ^ hist[g];
        end
    end

    // A fresh event wins over a read clearing the same flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= hit | (flags & {LINES{~rd_stb}});
        end
    end
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import msr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dcd_n,
    input  logic       ri_n,
    input  logic       dsr_n,
    input  logic       cts_n,
    input  logic       loop_en,
    input  logic [3:0] mctl,
    input  logic       rd_stb,
    output logic [7:0] rd_data
);
    logic [LINES-1:0] pins_n_raw;
    logic [LINES-1:0] pins_n_sync;
    msr_lines_t       status_s;
    logic [LINES-1:0] line_status;
    logic [LINES-1:0] line_hist;
    logic [LINES-1:0] line_flags;
    msr_byte_t        out_byte;

    assign pins_n_raw = {dcd_n, ri_n, dsr_n, cts_n};

    msr_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_n_raw),
        .dout (pins_n_sync)
    );

    msr_line_source u_src (
        .pins_n_sync (pins_n_sync),
        .loop_en     (loop_en),
        .mctl        (mctl),
        .status      (status_s)
    );

    assign line_status = status_s;

    msr_delta_flags u_delta (
        .clk    (clk),
        .rst    (rst),
        .status (line_status),
        .rd_stb (rd_stb),
        .hist   (line_hist),
        .flags  (line_flags)
    );

    always_comb begin
        out_byte.status = status_s;
        out_byte.flags  = msr_lines_t'(line_flags);
    end

    assign rd_data = out_byte;
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_stb,
    input logic       loop_en,
    input logic [3:0] mctl,
    input logic [7:0] rd_data,
    input logic [3:0] status,
    input logic [3:0] hist
);
    assert_loop_map_R3: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (rd_data[7:4] == {mctl[3], mctl[2], mctl[0], mctl[1]}));

    assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (status == hist)) |=> (rd_data[3:0] == 4'b0000));

    assert_any_edge_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (((status ^ hist) & 4'b1011) != 4'b0000)
        |=> ((rd_data[3:0] & $past((status ^ hist) & 4'b1011)) == $past((status ^ hist) & 4'b1011)));

    assert_ring_rise_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (status[2] && !hist[2]) |=> rd_data[2]);

    assert_ring_only_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[2]) |-> ($past(status[2]) && !$past(hist[2])));
endmodule

bind modem_status_reg msr_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (rd_stb),
    .loop_en (loop_en),
    .mctl    (mctl),
    .rd_data (rd_data),
    .status  (line_status),
    .hist    (line_hist)
);

// File: tb/sim_modem_status_reg.sv
module sim_modem_status_reg;
    logic       clk = 1'b0;
    logic       rst;
    logic       dcd_n, ri_n, dsr_n, cts_n;
    logic       loop_en;
    logic [3:0] mctl;
    logic       rd_stb;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    modem_status_reg u0 (
        .clk     (clk),
        .rst     (rst),
        .dcd_n   (dcd_n),
        .ri_n    (ri_n),
        .dsr_n   (dsr_n),
        .cts_n   (cts_n),
        .loop_en (loop_en),
        .mctl    (mctl),
        .rd_stb  (rd_stb),
        .rd_data (rd_data)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [7:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s rd_data=%02h expected=%02h", req, rd_data, exp);
        end
    endtask

    // One read cycle: shows pre-clear byte, then the byte after the clear.
    task automatic do_read(input string req, input logic [7:0] before_v, input logic [7:0] after_v);
        rd_stb = 1'b1;
        #0.5;
        chk(req, before_v);
        step(1);
        rd_stb = 1'b0;
        #0.5;
        chk(req, after_v);
    endtask

    task automatic t_reset;
        rst = 1'b1; dcd_n = 1'b1; ri_n = 1'b1; dsr_n = 1'b1; cts_n = 1'b1;
        loop_en = 1'b0; mctl = 4'h0; rd_stb = 1'b0;
        step(3);
        chk("R1", 8'h00);
        rst = 1'b0;
        step(1);
        chk("R1", 8'h00);
        step(4);
        chk("R9", 8'h00);
    endtask

    task automatic t_pins_any_edge;
        dcd_n = 1'b0;
        step(2);
        chk("R2", 8'h80);
        step(1);
        chk("R4", 8'h88);
        do_read("R6", 8'h88, 8'h80);
        step(2);
        chk("R6", 8'h80);
        dsr_n = 1'b0; cts_n = 1'b0;
        step(3);
        chk("R2", 8'hB3);
        do_read("R6", 8'hB3, 8'hB0);
        dcd_n = 1'b1; dsr_n = 1'b1; cts_n = 1'b1;
        step(3);
        chk("R4", 8'h0B);
        do_read("R6", 8'h0B, 8'h00);
    endtask

    task automatic t_ring_edge;
        ri_n = 1'b0;
        step(3);
        chk("R5", 8'h44);
        do_read("R5", 8'h44, 8'h40);
        ri_n = 1'b1;
        step(3);
        chk("R5", 8'h00);
        step(2);
        chk("R5", 8'h00);
    endtask

    task automatic t_read_collision;
        dcd_n = 1'b0;
        step(3);
        chk("R7", 8'h88);
        dcd_n = 1'b1;
        step(2);
        chk("R7", 8'h08);
        do_read("R7", 8'h08, 8'h08);
        do_read("R7", 8'h08, 8'h00);
    endtask

    task automatic t_loopback;
        mctl = 4'h0;
        loop_en = 1'b1;
        step(1);
        chk("R8", 8'h00);
        mctl = 4'b1001;
        #0.5;
        chk("R3", 8'hA0);
        step(1);
        chk("R8", 8'hAA);
        do_read("R8", 8'hAA, 8'hA0);
        mctl = 4'b0110;
        #0.5;
        chk("R3", 8'h50);
        step(1);
        chk("R8", 8'h5F);
        do_read("R8", 8'h5F, 8'h50);
        dcd_n = 1'b0; ri_n = 1'b0; dsr_n = 1'b0; cts_n = 1'b0;
        step(4);
        chk("R8", 8'h50);
        mctl = 4'h0;
        step(1);
        chk("R5", 8'h01);
        do_read("R8", 8'h01, 8'h00);
        mctl = 4'b0010;
        rd_stb = 1'b1;
        step(1);
        rd_stb = 1'b0;
        chk("R7", 8'h11);
        mctl = 4'h0;
        step(1);
        do_read("R8", 8'h01, 8'h00);
        dcd_n = 1'b1; ri_n = 1'b1; dsr_n = 1'b1; cts_n = 1'b1;
        step(4);
        loop_en = 1'b0;
        step(2);
        chk("R2", 8'h00);
    endtask

    initial begin
        t_reset();
        t_pins_any_edge();
        t_ring_edge();
        t_read_collision();
        t_loopback();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule